// File: doc/BRIEF.md
# Signed Magnitude-Path Array Multiplier

This block multiplies two WIDTH-bit two's-complement numbers and produces their exact 2*WIDTH-bit two's-complement product. It handles signs outside the arithmetic core. Each operand is first turned into an unsigned magnitude. The two magnitudes go through a plain unsigned array: one row of AND gates per multiplier bit, and those rows are summed by rows of ripple full adders. The unsigned result is then negated whenever exactly one operand was negative.

The operand width is a parameter. Each extra bit of width adds one more partial-product row and one more adder row. Two optional register stages help with timing. IN_REG captures the operands before the arithmetic, and OUT_REG captures the product after it. The pipeline accepts a new operand pair on every clock cycle.

Top module: `smul_top`

## Requirements
- R1: Operands `a_i` and `b_i` are two's-complement values whose top bit is the sign (1 = negative). `p_o` is their exact signed product, as a 2*WIDTH-bit two's-complement value.
- R2: When both operands are nonzero, the top bit of `p_o` equals the XOR of the two operand sign bits.
- R3: When either operand is zero, `p_o` is all zeros, whatever the sign of the other operand.
- R4: The most-negative value times itself, -2^(WIDTH-1) * -2^(WIDTH-1), gives exactly +2^(2*WIDTH-2). This is a 0 in the top bit and a single 1 in bit 2*WIDTH-2.
- R5: The most-negative value times -1 gives +2^(WIDTH-1), and times +1 gives itself sign-extended to 2*WIDTH bits.
- R6: The product of the operands present before a rising edge appears IN_REG+OUT_REG edges later. A new operand pair is accepted on every cycle, so one product emerges per cycle.
- R7: While `rst_n` is low, and on the first edge after it is released, `p_o` is all zeros (when IN_REG+OUT_REG > 0).
- R8: The same RTL gives correct products at WIDTH = 4, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register stages |
| a_i | input | WIDTH | Multiplicand, two's complement |
| b_i | input | WIDTH | Multiplier, two's complement |
| p_o | output | 2*WIDTH | Signed product, two's complement |

## Verification
With both register stages on, a pair applied at one falling edge is captured by the next rising edge. Its product is registered on the rising edge after that, so it is due at the second falling edge following the apply. The bench drives operands on falling edges and samples `p_o` on the falling edge exactly two rising edges later. The streaming test reuses that offset: it checks each cycle's output against the pair driven two cycles before it, and so confirms that a product is produced every cycle.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;
endpackage

// File: rtl/smul_fa.sv
module smul_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = x_i ^ y_i ^ c_i;
    assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/smul_mag.sv
// Splits a two's-complement value into sign and n-bit unsigned magnitude.
module smul_mag #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    logic [WIDTH-1:0] inv_plus_one;

    assign neg_o        = x_i[WIDTH-1];
    assign inv_plus_one = ~x_i + {{(WIDTH-1){1'b0}}, 1'b1};
    // most-negative input maps to 2^(WIDTH-1), valid as unsigned
    assign mag_o        = neg_o ? inv_plus_one : x_i;
endmodule

// File: rtl/smul_negate.sv
module smul_negate #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] y_o
);
    logic [WIDTH-1:0] twos;

    assign twos = ~x_i + {{(WIDTH-1){1'b0}}, 1'b1};
    assign y_o  = en_i ? twos : x_i;
endmodule

// File: rtl/smul_array.sv
// Unsigned WIDTH x WIDTH array: AND partial products, ripple full-adder rows.
module smul_array #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [2*WIDTH-1:0] p_o
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] pp  [WIDTH];
    logic [WIDTH:0]   row [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_pp
        assign pp[i] = a_i & {WIDTH{b_i[i]}};
    end

    assign row[0] = {1'b0, pp[0]};

    for (genvar r = 1; r < WIDTH; r++) begin : g_row
        logic [WIDTH:0]   cy;
        logic [WIDTH-1:0] sm;
        assign cy[0] = 1'b0;
        for (genvar j = 0; j < WIDTH; j++) begin : g_col
            smul_fa u_fa (
                .x_i (row[r-1][j+1]),
                .y_i (pp[r][j]),
                .c_i (cy[j]),
                .s_o (sm[j]),
                .c_o (cy[j+1])
            );
        end
        assign row[r] = {cy[WIDTH], sm};
    end

    for (genvar k = 0; k < WIDTH - 1; k++) begin : g_low
        assign p_o[k] = row[k][0];
    end
    assign p_o[PW-1:WIDTH-1] = row[WIDTH-1];
endmodule

// File: rtl/smul_top.sv
module smul_top #(
    parameter int WIDTH   = 8,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     a_i,
    input  logic [WIDTH-1:0]     b_i,
    output logic [2*WIDTH-1:0]   p_o
);
    import smul_pkg::*;

    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [PW-1:0]    p;
    } stage_t;

    stage_t st_d, st_q;

    logic [WIDTH-1:0] a_s, b_s;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic             neg_a, neg_b;
    logic [PW-1:0]    uprod;
    logic [PW-1:0]    p_c;
    sign_e            psign;

    if (IN_REG) begin : g_in_reg
        assign a_s = st_q.a;
        assign b_s = st_q.b;
    end else begin : g_in_pass
        assign a_s = a_i;
        assign b_s = b_i;
    end

    smul_mag #(.WIDTH(WIDTH)) u_mag_a (.x_i(a_s), .mag_o(mag_a), .neg_o(neg_a));
    smul_mag #(.WIDTH(WIDTH)) u_mag_b (.x_i(b_s), .mag_o(mag_b), .neg_o(neg_b));

    smul_array #(.WIDTH(WIDTH)) u_array (
        .a_i (mag_a),
        .b_i (mag_b),
        .p_o (uprod)
    );

    assign psign = (neg_a ^ neg_b) ? SIGN_NEG : SIGN_POS;

    smul_negate #(.WIDTH(PW)) u_neg (
        .x_i  (uprod),
        .en_i (psign == SIGN_NEG),
        .y_o  (p_c)
    );

    always_comb begin
        st_d   = st_q;
        st_d.a = a_i;
        st_d.b = b_i;
        st_d.p = p_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    if (OUT_REG) begin : g_out_reg
        assign p_o = st_q.p;
    end else begin : g_out_pass
        assign p_o = p_c;
    end
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int WIDTH   = 8,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [WIDTH-1:0]     a_i,
    input logic [WIDTH-1:0]     b_i,
    input logic [2*WIDTH-1:0]   p_o
);
    localparam int PW  = 2 * WIDTH;
    localparam int LAT = int'(IN_REG) + int'(OUT_REG);
    localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONEV = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] ah [3];
    logic [WIDTH-1:0] bh [3];
    logic [1:0]       cnt;
    logic             valid;
    logic [WIDTH-1:0] a_d, b_d;

    assign ah[0] = a_i;
    assign bh[0] = b_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ah[1] <= '0; ah[2] <= '0;
            bh[1] <= '0; bh[2] <= '0;
            cnt   <= '0;
        end else begin
            ah[1] <= ah[0]; ah[2] <= ah[1];
            bh[1] <= bh[0]; bh[2] <= bh[1];
            if (cnt != 2'd3) cnt <= cnt + 2'd1;
        end
    end

    assign valid = (int'(cnt) >= LAT);
    assign a_d   = ah[LAT];
    assign b_d   = bh[LAT];

    // R2
    prod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && a_d != '0 && b_d != '0) |-> (p_o[PW-1] == (a_d[WIDTH-1] ^ b_d[WIDTH-1])));

    // R3
    zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (a_d == '0 || b_d == '0)) |-> (p_o == '0));

    // R4
    min_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && a_d == MINV && b_d == MINV) |-> (p_o == ({{(PW-1){1'b0}}, 1'b1} << (PW - 2))));

    // R5
    unit_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && b_d == ONEV) |-> (p_o == {{WIDTH{a_d[WIDTH-1]}}, a_d}));

    if (LAT > 0) begin : g_rst_chk
        // R7
        post_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == 2'd0) |-> (p_o == '0));
    end
endmodule

bind smul_top smul_chk #(.WIDTH(WIDTH), .IN_REG(IN_REG), .OUT_REG(OUT_REG)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .p_o   (p_o)
);

// File: tb/sim_smul_top.sv
`timescale 1ns/1ps
module sim_smul_top;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] a16 = '0, b16 = '0;
    logic [7:0]  p4;
    logic [15:0] p8;
    logic [31:0] p16;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    smul_top #(.WIDTH(4))  u0 (.clk(clk), .rst_n(rst_n), .a_i(a4),  .b_i(b4),  .p_o(p4));
    smul_top #(.WIDTH(8))  u1 (.clk(clk), .rst_n(rst_n), .a_i(a8),  .b_i(b8),  .p_o(p8));
    smul_top #(.WIDTH(16)) u2 (.clk(clk), .rst_n(rst_n), .a_i(a16), .b_i(b16), .p_o(p16));

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint exp4(input logic [3:0] a, input logic [3:0] b);
        return (longint'($signed(a)) * longint'($signed(b))) & 64'hFF;
    endfunction
    function automatic longint exp8(input logic [7:0] a, input logic [7:0] b);
        return (longint'($signed(a)) * longint'($signed(b))) & 64'hFFFF;
    endfunction
    function automatic longint exp16(input logic [15:0] a, input logic [15:0] b);
        return (longint'($signed(a)) * longint'($signed(b))) & 64'hFFFF_FFFF;
    endfunction

    // drive at a falling edge, sample LAT rising edges later on a falling edge
    task automatic apply(input string req,
                         input logic [3:0] xa4,  input logic [3:0] xb4,
                         input logic [7:0] xa8,  input logic [7:0] xb8,
                         input logic [15:0] xa16, input logic [15:0] xb16);
        @(negedge clk);
        a4 = xa4; b4 = xb4; a8 = xa8; b8 = xb8; a16 = xa16; b16 = xb16;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check({req, " w4"},  longint'(p4),  exp4(xa4, xb4));
        check({req, " w8"},  longint'(p8),  exp8(xa8, xb8));
        check({req, " w16"}, longint'(p16), exp16(xa16, xb16));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R7: outputs zero during reset even with nonzero operands
        a4 = 4'hD; b4 = 4'h5; a8 = 8'h93; b8 = 8'h27; a16 = 16'h8001; b16 = 16'h7FFF;
        repeat (3) @(negedge clk);
        check("R7 reset w4",  longint'(p4),  0);
        check("R7 reset w8",  longint'(p8),  0);
        check("R7 reset w16", longint'(p16), 0);
        rst_n = 1'b1;

        // R1 R2 R3: exhaustive at WIDTH=4, random at 8 and 16
        for (int i = 0; i < 256; i++) begin
            apply("R1 sweep", i[7:4], i[3:0], 8'($urandom), 8'($urandom),
                  16'($urandom), 16'($urandom));
        end

        // R3: zero against every sign
        apply("R3 zero", 4'h0, 4'h8, 8'h80, 8'h00, 16'h0000, 16'hFFFF);
        apply("R3 zero", 4'hF, 4'h0, 8'h00, 8'hFF, 16'h8000, 16'h0000);
        // R4: most-negative squared
        apply("R4 min*min", 4'h8, 4'h8, 8'h80, 8'h80, 16'h8000, 16'h8000);
        // R5: most-negative times -1 and +1
        apply("R5 min*-1", 4'h8, 4'hF, 8'h80, 8'hFF, 16'h8000, 16'hFFFF);
        apply("R5 min*1",  4'h8, 4'h1, 8'h80, 8'h01, 16'h8000, 16'h0001);
        apply("R2 -1*-1",  4'hF, 4'hF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF);
        apply("R2 max*min", 4'h7, 4'h8, 8'h7F, 8'h80, 16'h7FFF, 16'h8000);

        // R8: extra random coverage at wider settings
        for (int i = 0; i < 300; i++) begin
            apply("R8 random", 4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
                  16'($urandom), 16'($urandom));
        end

        // R6: back-to-back stream, one new pair each cycle
        begin
            logic [3:0] ha [40];
            logic [3:0] hb [40];
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                if (t >= LAT) begin
                    check("R6 stream", longint'(p4), exp4(ha[t-LAT], hb[t-LAT]));
                end
                ha[t] = 4'($urandom);
                hb[t] = 4'(t);
                a4 = ha[t];
                b4 = hb[t];
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule